// File: doc/BRIEF.md
# Same-Colour Pixel Bus Encoder and Decoder

This block sits on the output bus of a colour image sensor and cuts wire toggling on that bus. Each pixel arrives with a colour tag. The encoder keeps, for every colour channel, the upper six bits of the last pixel of that channel. If a new pixel's upper six bits match that stored value, the encoder leaves the upper bus lines as they were and raises a hold flag. If they differ, it drives the new upper bits. The lower bits always pass through unchanged.

The decoder keeps its own copy of the per-colour upper bits. It uses the hold flag to rebuild the original pixel. Both halves sit in one top module so the link can be checked end to end. The encoded bus is brought out as ports because it is the wire set whose activity the block reduces. A valid strobe qualifies each pixel. Idle cycles change neither the bus nor any history.

Top module: `pxc_codec`

## Requirements
- R1: While reset is asserted, `bus_valid`, `bus_hold`, `out_valid`, `bus_word` and `out_pix` are all zero. Every per-colour history is marked empty.
- R2: A pixel taken with `in_valid` high appears on the encoded bus one cycle later with `bus_valid` high. It appears rebuilt on `out_pix` with `out_valid` high two cycles after it was taken.
- R3: For every valid pixel, the bits of `bus_word` below the top six equal the same bits of the pixel.
- R4: When the top six bits (`in_pix[PIX_W-1:PIX_W-6]`) equal the stored top six bits of the previous valid pixel with the same colour tag, `bus_hold` is 1. The top six bits of `bus_word` keep the value they had on the previous cycle.
- R5: When the top six bits differ from the stored value of that colour, `bus_hold` is 0 and the top six bits of `bus_word` carry the new pixel's top six bits.
- R6: After reset, the first valid pixel of each colour tag is sent in full with `bus_hold` 0, whatever its value.
- R7: A cycle with `in_valid` low gives `bus_valid` 0 and `bus_hold` 0 on the next cycle. It leaves `bus_word` unchanged and updates no history.
- R8: The 2-bit colour tag (0 to 3) selects one of four independent histories. A pixel of one colour never causes a hold decision against another colour's history.
- R9: `out_pix` and `out_color` equal the `in_pix` and `in_color` of the pixel taken two cycles earlier, for both random and strongly correlated pixel streams.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the pixel on `in_pix` |
| in_color | input | COLOR_W | Colour channel tag of the pixel |
| in_pix | input | PIX_W | Raw pixel word |
| bus_valid | output | 1 | Encoded bus carries a pixel this cycle |
| bus_color | output | COLOR_W | Colour tag travelling with the encoded word |
| bus_word | output | PIX_W | Encoded bus lines |
| bus_hold | output | 1 | Upper six bus lines are held; use stored bits |
| out_valid | output | 1 | Rebuilt pixel is present |
| out_color | output | COLOR_W | Colour tag of the rebuilt pixel |
| out_pix | output | PIX_W | Rebuilt pixel word |

## Verification
The encoded-bus outputs (`bus_valid`, `bus_hold`, `bus_word`) belong to the edge after the pixel is taken. The rebuilt outputs (`out_valid`, `out_color`, `out_pix`) belong to the edge after that. The bench drives on the falling edge and reads the bus one falling edge later and the rebuilt pixel two falling edges later. In the streaming tests it checks sample k-1 on the bus and sample k-2 at the output in the same cycle that it drives sample k. The expected hold flag and the held upper bits come from the bench's own per-colour model and its own copy of the last bus word.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
    // Channel naming for a Bayer-style mosaic; the tag value selects history
    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GRN_R = 2'd1,
        CH_GRN_B = 2'd2,
        CH_BLUE  = 2'd3
    } chan_e;

    localparam int HOLD_FIELD_W = 6;
endpackage

// File: rtl/pxc_history.sv
module pxc_history #(
    parameter int NCOL = 4,
    parameter int UW   = 6,
    localparam int SW  = (NCOL > 1) ? $clog2(NCOL) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [UW-1:0] wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [UW-1:0] rd_data,
    output logic          rd_valid
);
    logic [UW-1:0] ent_q [NCOL];
    logic [NCOL-1:0] vld_q;

    for (genvar g = 0; g < NCOL; g++) begin : g_ent
        logic          hit;
        logic [UW-1:0] ent_d;
        logic          vld_d;
        always_comb begin
            hit   = wr_en && (wr_sel == SW'(g));
            ent_d = hit ? wr_data : ent_q[g];
            vld_d = hit ? 1'b1 : vld_q[g];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
                vld_q[g] <= 1'b0;
            end else begin
                ent_q[g] <= ent_d;
                vld_q[g] <= vld_d;
            end
        end
    end

    always_comb begin
        rd_data  = ent_q[rd_sel];
        rd_valid = vld_q[rd_sel];
    end
endmodule

// File: rtl/pxc_encoder.sv
module pxc_encoder #(
    parameter int PIX_W   = 12,
    parameter int COLOR_W = 2,
    localparam int UW     = pxc_pkg::HOLD_FIELD_W,
    localparam int LW     = PIX_W - UW,
    localparam int NCOL   = 1 << COLOR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COLOR_W-1:0] in_color,
    input  logic [PIX_W-1:0]   in_pix,
    output logic               bus_valid,
    output logic [COLOR_W-1:0] bus_color,
    output logic [PIX_W-1:0]   bus_word,
    output logic               bus_hold
);
    typedef struct packed {
        logic               vld;
        logic               hold;
        logic [COLOR_W-1:0] col;
        logic [PIX_W-1:0]   word;
    } enc_st_t;

    enc_st_t       st_d, st_q;
    logic [UW-1:0] in_upper;
    logic [UW-1:0] hist_data;
    logic          hist_vld;
    logic          match;

    assign in_upper = in_pix[PIX_W-1 -: UW];

    pxc_history #(.NCOL(NCOL), .UW(UW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (in_valid),
        .wr_sel   (in_color),
        .wr_data  (in_upper),
        .rd_sel   (in_color),
        .rd_data  (hist_data),
        .rd_valid (hist_vld)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.hold = 1'b0;
        match     = hist_vld && (hist_data == in_upper);
        if (in_valid) begin
            st_d.col           = in_color;
            st_d.word[LW-1:0]  = in_pix[LW-1:0];
            st_d.hold          = match;
            if (!match) begin
                st_d.word[PIX_W-1 -: UW] = in_upper;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_valid = st_q.vld;
    assign bus_color = st_q.col;
    assign bus_word  = st_q.word;
    assign bus_hold  = st_q.hold;

    // R7: idle input leaves the bus lines untouched
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!bus_valid && !bus_hold && $stable(bus_word)));

    // R3: low bits pass straight through
    a_r3_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (bus_word[LW-1:0] == $past(in_pix[LW-1:0])));

    // R4: a held word keeps its upper lines
    a_r4_hold_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_hold) |-> (bus_word[PIX_W-1 -: UW] == $past(bus_word[PIX_W-1 -: UW])));

    // R5: an unheld word carries the new upper bits
    a_r5_send_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_hold) |-> (bus_word[PIX_W-1 -: UW] == $past(in_pix[PIX_W-1 -: UW])));
endmodule

// File: rtl/pxc_decoder.sv
module pxc_decoder #(
    parameter int PIX_W   = 12,
    parameter int COLOR_W = 2,
    localparam int UW     = pxc_pkg::HOLD_FIELD_W,
    localparam int LW     = PIX_W - UW,
    localparam int NCOL   = 1 << COLOR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic [COLOR_W-1:0] bus_color,
    input  logic [PIX_W-1:0]   bus_word,
    input  logic               bus_hold,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color,
    output logic [PIX_W-1:0]   out_pix
);
    typedef struct packed {
        logic               vld;
        logic [COLOR_W-1:0] col;
        logic [PIX_W-1:0]   pix;
    } dec_st_t;

    dec_st_t       st_d, st_q;
    logic [UW-1:0] hist_data;
    logic          hist_vld;
    logic [UW-1:0] upper;

    always_comb begin
        upper = bus_hold ? hist_data : bus_word[PIX_W-1 -: UW];
    end

    pxc_history #(.NCOL(NCOL), .UW(UW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_valid),
        .wr_sel   (bus_color),
        .wr_data  (upper),
        .rd_sel   (bus_color),
        .rd_data  (hist_data),
        .rd_valid (hist_vld)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = bus_valid;
        if (bus_valid) begin
            st_d.col = bus_color;
            st_d.pix = {upper, bus_word[LW-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_color = st_q.col;
    assign out_pix   = st_q.pix;

    // R6: a hold may only arrive for a colour the decoder has already seen
    a_r6_hold_has_history: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_hold) |-> hist_vld);

    // R2: each bus word yields a rebuilt pixel one cycle later
    a_r2_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> out_valid);

    // R9: rebuilt low bits equal the bus low bits
    a_r9_low_rebuilt: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> (out_pix[LW-1:0] == $past(bus_word[LW-1:0])));
endmodule

// File: rtl/pxc_codec.sv
module pxc_codec #(
    parameter int PIX_W   = 12,
    parameter int COLOR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COLOR_W-1:0] in_color,
    input  logic [PIX_W-1:0]   in_pix,
    output logic               bus_valid,
    output logic [COLOR_W-1:0] bus_color,
    output logic [PIX_W-1:0]   bus_word,
    output logic               bus_hold,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color,
    output logic [PIX_W-1:0]   out_pix
);
    pxc_encoder #(.PIX_W(PIX_W), .COLOR_W(COLOR_W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_color  (in_color),
        .in_pix    (in_pix),
        .bus_valid (bus_valid),
        .bus_color (bus_color),
        .bus_word  (bus_word),
        .bus_hold  (bus_hold)
    );

    pxc_decoder #(.PIX_W(PIX_W), .COLOR_W(COLOR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_color (bus_color),
        .bus_word  (bus_word),
        .bus_hold  (bus_hold),
        .out_valid (out_valid),
        .out_color (out_color),
        .out_pix   (out_pix)
    );

    // R1: reset clears every output
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!bus_valid && !bus_hold && !out_valid && bus_word == '0 && out_pix == '0));
endmodule

// File: tb/tb_pxc_codec.sv
`timescale 1ns/1ps
module tb_pxc_codec;
    localparam int PIX_W = 12;
    localparam int UW    = 6;
    localparam int LW    = PIX_W - UW;
    localparam int NV    = 13;
    localparam int NS    = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [1:0]       in_color = '0;
    logic [PIX_W-1:0] in_pix = '0;
    logic             bus_valid, bus_hold, out_valid;
    logic [1:0]       bus_color, out_color;
    logic [PIX_W-1:0] bus_word, out_pix;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pxc_codec #(.PIX_W(PIX_W), .COLOR_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_color(in_color),
        .in_pix(in_pix), .bus_valid(bus_valid), .bus_color(bus_color),
        .bus_word(bus_word), .bus_hold(bus_hold), .out_valid(out_valid),
        .out_color(out_color), .out_pix(out_pix)
    );

    // vector: {valid, colour[1:0], pixel[11:0], expect_hold, first_of_colour}
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 2'd0, 12'hABC, 1'b0, 1'b1},
        {1'b1, 2'd1, 12'hAB0, 1'b0, 1'b1},
        {1'b1, 2'd0, 12'hA80, 1'b1, 1'b0},
        {1'b0, 2'd0, 12'hFFF, 1'b0, 1'b0},
        {1'b1, 2'd0, 12'h000, 1'b0, 1'b0},
        {1'b1, 2'd1, 12'hABF, 1'b1, 1'b0},
        {1'b1, 2'd2, 12'h555, 1'b0, 1'b1},
        {1'b1, 2'd3, 12'h3C0, 1'b0, 1'b1},
        {1'b1, 2'd2, 12'h57F, 1'b1, 1'b0},
        {1'b0, 2'd2, 12'h000, 1'b0, 1'b0},
        {1'b1, 2'd3, 12'h3FF, 1'b1, 1'b0},
        {1'b1, 2'd0, 12'h03F, 1'b1, 1'b0},
        {1'b1, 2'd2, 12'h540, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // bench model state for streaming tests
    logic [UW-1:0] mh [4];
    bit            mv [4];
    logic [UW-1:0] mbus;

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin mh[i] = '0; mv[i] = 0; end
        mbus = '0;
    endtask

    task automatic run_stream(input bit correlated);
        bit               sv [NS];
        logic [1:0]       sc [NS];
        logic [PIX_W-1:0] sp [NS];
        logic [PIX_W-1:0] base [4];
        for (int i = 0; i < 4; i++) base[i] = PIX_W'($urandom);
        for (int k = 0; k < NS; k++) begin
            sv[k] = ($urandom % 5) != 0;
            sc[k] = 2'(k % 4);
            if (correlated) begin
                base[sc[k]] = base[sc[k]] + PIX_W'($urandom % 9) - PIX_W'(4);
                sp[k] = base[sc[k]];
            end else begin
                sp[k] = PIX_W'($urandom);
            end
        end
        for (int k = 0; k < NS + 2; k++) begin
            @(negedge clk);
            if (k >= 1) begin
                int j = k - 1;
                if (sv[j]) begin
                    logic [UW-1:0] up;
                    bit            m;
                    up = sp[j][PIX_W-1 -: UW];
                    m  = mv[sc[j]] && (mh[sc[j]] == up);
                    if (!m) mbus = up;
                    mh[sc[j]] = up;
                    mv[sc[j]] = 1;
                    chk(bus_valid == 1'b1, "R2 stream bus_valid", int'(bus_valid), 1);
                    chk(bus_hold == m, m ? "R4 stream hold" : "R5 stream no hold",
                        int'(bus_hold), int'(m));
                    chk(bus_word[PIX_W-1 -: UW] == mbus, "R4 stream upper lines",
                        int'(bus_word[PIX_W-1 -: UW]), int'(mbus));
                end else begin
                    chk(!bus_valid && !bus_hold, "R7 stream idle", int'(bus_valid), 0);
                end
            end
            if (k >= 2 && sv[k-2]) begin
                chk(out_valid && out_pix == sp[k-2] && out_color == sc[k-2],
                    correlated ? "R9 correlated rebuild" : "R9 random rebuild",
                    int'(out_pix), int'(sp[k-2]));
            end
            if (k < NS) begin
                in_valid = sv[k];
                in_color = sc[k];
                in_pix   = sp[k];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [PIX_W-1:0] prev_bus;
        logic [PIX_W-1:0] exp_word;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk(!bus_valid && !bus_hold && !out_valid, "R1 reset flags", int'(bus_valid), 0);
        chk(bus_word == '0 && out_pix == '0, "R1 reset words", int'(bus_word), 0);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic             v, eh, fst;
            logic [1:0]       c;
            logic [PIX_W-1:0] p;
            {v, c, p, eh, fst} = VEC[i];
            @(negedge clk);
            prev_bus = bus_word;
            in_valid = v; in_color = c; in_pix = p;
            @(negedge clk);
            if (v) begin
                exp_word = {eh ? prev_bus[PIX_W-1 -: UW] : p[PIX_W-1 -: UW], p[LW-1:0]};
                chk(bus_valid == 1'b1, "R2 bus after one cycle", int'(bus_valid), 1);
                chk(bus_hold == eh, eh ? "R4 hold on match R8" : (fst ? "R6 first of colour" : "R5 new upper"),
                    int'(bus_hold), int'(eh));
                chk(bus_word[LW-1:0] == p[LW-1:0], "R3 low bits", int'(bus_word[LW-1:0]), int'(p[LW-1:0]));
                chk(bus_word == exp_word, eh ? "R4 upper held" : "R5 upper sent", int'(bus_word), int'(exp_word));
            end else begin
                chk(!bus_valid && !bus_hold && bus_word == prev_bus, "R7 idle no change",
                    int'(bus_word), int'(prev_bus));
            end
            in_valid = 1'b0;
            @(negedge clk);
            if (v) begin
                chk(out_valid && out_pix == p && out_color == c, "R2 R9 rebuilt pixel",
                    int'(out_pix), int'(p));
            end
        end

        // streaming: random then correlated, back to back
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_clear();
        run_stream(1'b0);
        run_stream(1'b1);

        // reset mid-run, then history must be empty again
        @(negedge clk);
        in_valid = 1'b1; in_color = 2'd1; in_pix = 12'h7C3;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk(!bus_valid && !out_valid && bus_word == '0, "R1 reset mid-run", int'(bus_word), 0);
        rst_n = 1'b1;
        in_valid = 1'b1; in_color = 2'd1; in_pix = 12'h7C4;
        @(negedge clk);
        in_valid = 1'b0;
        chk(bus_hold == 1'b0 && bus_word == 12'h7C4, "R6 first after reset",
            int'(bus_word), 32'h7C4);
        @(negedge clk);
        chk(out_valid && out_pix == 12'h7C4, "R9 rebuild after reset", int'(out_pix), 32'h7C4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule